// File: doc/BRIEF.md
# Lines-per-field word receiver and video format classifier

This block sits in the system clock domain beside an analog sync separator. The separator sends the count of horizontal lines in each field as an 11-bit serial word on a single data pin. It changes that pin on the falling (leading) edge of its active-low horizontal sync and frames the word with its active-low vertical sync. The block finds the leading edges of both syncs and measures each line in system clocks. It samples the data pin once per line, half a line after the horizontal leading edge, well away from the moment the data changes. From these samples it rebuilds the word, most significant bit first.

Each finished word is compared with the nominal line counts of seven broadcast formats, with a tolerance of one line. A recognised format is published only when two consecutive fields agree. For interlaced formats the block also reports which field is in progress, and it keeps a flag that marks standard-definition composite video. A word that fits no format raises an unknown flag and leaves the published format as it was.

Top module: `fmt_word_rx`

## Requirements
- R1: After reset, `fmt_code` is 0 (no format), `field_odd` is 1, `composite` is 0 and `unknown` is 0.
- R2: A word is taken from 11 consecutive lines. The first bit, which is the MSB, is the level present during the line that begins with the 3rd `hs_n` falling edge after the `vs_n` falling edge. Following bits come from the lines after it, down to the LSB.
- R3: In each line the data pin is sampled once, at half of the previous line's length (in clocks) after the `hs_n` falling edge. Data levels held only during the first cycles after the edge have no effect.
- R4: The codes are 1 for 525-line interlace (259/260), 2 for 625-line interlace (309/310), 3 for 525-line progressive (522), 4 for 625-line progressive (622), 5 for 720p (747), 6 for 1080i (559/560) and 7 for 1080p (1122).
- R5: A word matches a format when it lies from one below the smaller nominal to one above the larger nominal. A word that matches no format sets `unknown` and leaves `fmt_code`, `field_odd` and `composite` unchanged. The next matching word clears `unknown`.
- R6: `fmt_code` is loaded only when a word matches the same format as the word immediately before it. An unmatched word breaks the run.
- R7: When the format is loaded, `composite` takes bit 8 of the word (the third bit from the MSB). This bit is 1 only for the two standard-definition interlaced formats.
- R8: When an interlaced format is loaded, `field_odd` is 1 if the word is at or above the larger nominal value and 0 otherwise. For progressive formats `field_odd` is 1.
- R9: Data on lines outside the 11-line window has no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_n | input | 1 | Active-low horizontal sync; its falling edge is the bit clock |
| vs_n | input | 1 | Active-low vertical sync; its falling edge starts the word framing |
| fmt_bit | input | 1 | Serial lines-per-field data |
| fmt_code | output | 3 | Confirmed format code (R4), 0 when none |
| field_odd | output | 1 | 1 for the odd field or for progressive video, 0 for the even field |
| composite | output | 1 | Standard-definition composite video flag |
| unknown | output | 1 | Last word matched no format |

## Verification
The assertions check four things on every cycle. The published format only changes right after a word completes. It stays put when the unknown flag rises. A progressive format always reports field 1, and the composite flag never accompanies a format other than the two standard-definition interlaced ones. Sampling happens at most once per line, and a completed word always follows a data sample. Only the bench scenarios can show the rest. These are the bit order and window alignment, the mid-line sample point against noise injected near the sync edge, the tolerance band edges, and the two-field confirmation run. The bench checks them with random words mixed into directed sequences.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

   typedef enum logic [2:0] {
      FMT_NONE  = 3'd0,
      FMT_525I  = 3'd1,
      FMT_625I  = 3'd2,
      FMT_525P  = 3'd3,
      FMT_625P  = 3'd4,
      FMT_720P  = 3'd5,
      FMT_1080I = 3'd6,
      FMT_1080P = 3'd7
   } fmt_e;

   typedef struct packed {
      logic hit;
      fmt_e code;
      logic odd;
   } cls_t;

   localparam int NUM_FMT = 7;
   localparam int TBL_W   = 11;

   // smaller nominal count per format, index i is code i+1
   function automatic int nom_lo(input int i);
      case (i)
         0: nom_lo = 259;
         1: nom_lo = 309;
         2: nom_lo = 522;
         3: nom_lo = 622;
         4: nom_lo = 747;
         5: nom_lo = 559;
         default: nom_lo = 1122;
      endcase
   endfunction

   // larger nominal count (equal to the smaller one when progressive)
   function automatic int nom_hi(input int i);
      case (i)
         0: nom_hi = 260;
         1: nom_hi = 310;
         5: nom_hi = 560;
         default: nom_hi = nom_lo(i);
      endcase
   endfunction

   function automatic cls_t classify(input logic [TBL_W-1:0] w, input int tol);
      cls_t r;
      int   v;
      v = int'(w);
      r = '{hit: 1'b0, code: FMT_NONE, odd: 1'b1};
      for (int i = 0; i < NUM_FMT; i++) begin
         if (v >= nom_lo(i) - tol && v <= nom_hi(i) + tol) begin
            r.hit  = 1'b1;
            r.code = fmt_e'(i + 1);
            r.odd  = (nom_lo(i) == nom_hi(i)) ? 1'b1 : (v >= nom_hi(i));
         end
      end
      return r;
   endfunction

   function automatic logic is_progressive(input fmt_e f);
      return (f == FMT_525P) || (f == FMT_625P) || (f == FMT_720P) || (f == FMT_1080P);
   endfunction

endpackage

// File: rtl/lpf_line_timer.sv
module lpf_line_timer #(
   parameter int CNT_W       = 12,
   parameter int SAMPLE_MODE = 0,
   parameter int FIXED_DLY   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_n,
   output logic hs_edge,
   output logic smp
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W < 4) begin : g_bad_cnt
      $error("lpf_line_timer: CNT_W too small");
   end
   if (SAMPLE_MODE != 0 && SAMPLE_MODE != 1) begin : g_bad_mode
      $error("lpf_line_timer: SAMPLE_MODE must be 0 or 1");
   end

   logic             hs_q;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] line_len;
   logic [CNT_W-1:0] target;
   logic             taken;

   assign hs_edge = hs_q & ~hs_n;

   if (SAMPLE_MODE == 0) begin : g_half
      assign target = line_len >> 1;
   end else begin : g_fixed
      assign target = CNT_W'(FIXED_DLY);
   end

   assign smp = !hs_edge && !taken && (target != '0) && (cnt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q     <= 1'b1;
         cnt      <= '0;
         line_len <= '0;
         taken    <= 1'b0;
      end else begin
         hs_q <= hs_n;
         if (hs_edge) begin
            line_len <= (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
            cnt      <= '0;
            taken    <= 1'b0;
         end else begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (smp) taken <= 1'b1;
         end
      end
   end

   // R3: a single data sample per line
   a_r3_one_sample_per_line: assert property (@(posedge clk) disable iff (!rst_n)
      smp |=> !smp);

endmodule

// File: rtl/lpf_shift_rx.sv
module lpf_shift_rx #(
   parameter int WORD_W     = 11,
   parameter int START_EDGE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vs_n,
   input  logic              hs_edge,
   input  logic              smp,
   input  logic              din,
   output logic              word_done,
   output logic [WORD_W-1:0] word
);
   localparam int LAST_IDX = START_EDGE + WORD_W - 1;
   localparam int MAX_IDX  = LAST_IDX + 1;
   localparam int IDX_W    = $clog2(MAX_IDX + 1);

   if (START_EDGE < 1) begin : g_bad_start
      $error("lpf_shift_rx: START_EDGE must be at least 1");
   end

   logic             vs_q;
   logic             vs_edge;
   logic [IDX_W-1:0] idx;
   logic             in_win;

   assign vs_edge = vs_q & ~vs_n;
   assign in_win  = (int'(idx) >= START_EDGE) && (int'(idx) <= LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q      <= 1'b1;
         idx       <= IDX_W'(MAX_IDX);
         word      <= '0;
         word_done <= 1'b0;
      end else begin
         vs_q      <= vs_n;
         word_done <= 1'b0;
         if (vs_edge)
            idx <= hs_edge ? IDX_W'(1) : '0;
         else if (hs_edge && int'(idx) != MAX_IDX)
            idx <= idx + 1'b1;
         if (smp && in_win) begin
            word      <= {word[WORD_W-2:0], din};
            word_done <= (int'(idx) == LAST_IDX);
         end
      end
   end

   // R2: a finished word always follows a data sample
   a_r2_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> $past(smp));

endmodule

// File: rtl/lpf_fmt_class.sv
module lpf_fmt_class
   import lpf_pkg::*;
#(
   parameter int WORD_W = 11,
   parameter int TOL    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_done,
   input  logic [WORD_W-1:0] word,
   output fmt_e              fmt_code,
   output logic              field_odd,
   output logic              composite,
   output logic              unknown
);
   localparam int COMP_BIT = WORD_W - 3;

   if (WORD_W != TBL_W) begin : g_bad_width
      $error("lpf_fmt_class: WORD_W must equal the table width");
   end
   if (TOL < 0 || TOL > 8) begin : g_bad_tol
      $error("lpf_fmt_class: TOL out of range");
   end

   cls_t cls;
   fmt_e prev_code;

   assign cls = classify(word[TBL_W-1:0], TOL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_code  <= FMT_NONE;
         field_odd <= 1'b1;
         composite <= 1'b0;
         unknown   <= 1'b0;
         prev_code <= FMT_NONE;
      end else if (word_done) begin
         if (!cls.hit) begin
            unknown   <= 1'b1;
            prev_code <= FMT_NONE;
         end else begin
            unknown   <= 1'b0;
            prev_code <= cls.code;
            if (cls.code == prev_code) begin
               fmt_code  <= cls.code;
               field_odd <= cls.odd;
               composite <= word[COMP_BIT];
            end
         end
      end
   end

   // R6: the published format moves only right after a finished word
   a_r6_update_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fmt_code) |-> $past(word_done));

   // R5: an unmatched word leaves the published format alone
   a_r5_hold_on_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unknown) |-> $stable(fmt_code) && $stable(composite));

   // R7: composite only with a standard-definition interlaced format
   a_r7_composite_sd_only: assert property (@(posedge clk) disable iff (!rst_n)
      composite |-> (fmt_code == FMT_525I || fmt_code == FMT_625I));

   // R8: progressive formats report field 1
   a_r8_progressive_field: assert property (@(posedge clk) disable iff (!rst_n)
      is_progressive(fmt_code) |-> field_odd);

endmodule

// File: rtl/fmt_word_rx.sv
module fmt_word_rx #(
   parameter int WORD_W      = 11,
   parameter int START_EDGE  = 3,
   parameter int CNT_W       = 12,
   parameter int SAMPLE_MODE = 0,
   parameter int FIXED_DLY   = 16,
   parameter int TOL         = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hs_n,
   input  logic       vs_n,
   input  logic       fmt_bit,
   output logic [2:0] fmt_code,
   output logic       field_odd,
   output logic       composite,
   output logic       unknown
);
   logic              hs_edge;
   logic              smp;
   logic              word_done;
   logic [WORD_W-1:0] word;
   lpf_pkg::fmt_e     code;

   lpf_line_timer #(
      .CNT_W(CNT_W), .SAMPLE_MODE(SAMPLE_MODE), .FIXED_DLY(FIXED_DLY)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .hs_n(hs_n), .hs_edge(hs_edge), .smp(smp)
   );

   lpf_shift_rx #(
      .WORD_W(WORD_W), .START_EDGE(START_EDGE)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .vs_n(vs_n), .hs_edge(hs_edge), .smp(smp),
      .din(fmt_bit), .word_done(word_done), .word(word)
   );

   lpf_fmt_class #(
      .WORD_W(WORD_W), .TOL(TOL)
   ) u_class (
      .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
      .fmt_code(code), .field_odd(field_odd), .composite(composite),
      .unknown(unknown)
   );

   assign fmt_code = code;

endmodule

// File: tb/sim_fmt_word_rx.sv
module sim_fmt_word_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hs_n = 1'b1;
   logic       vs_n = 1'b1;
   logic       fmt_bit = 1'b0;
   logic [2:0] fmt_code;
   logic       field_odd, composite, unknown;

   int n_checks = 0;
   int n_fail   = 0;

   // model state
   int m_prev = 0, m_fmt = 0, m_odd = 1, m_comp = 0, m_unk = 0;

   always #5ns clk = ~clk;

   fmt_word_rx u0 (
      .clk(clk), .rst_n(rst_n), .hs_n(hs_n), .vs_n(vs_n), .fmt_bit(fmt_bit),
      .fmt_code(fmt_code), .field_odd(field_odd), .composite(composite),
      .unknown(unknown)
   );

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // R4 table, written independently of the design
   function automatic int lo_of(input int c);
      case (c)
         1: return 259; 2: return 309; 3: return 522; 4: return 622;
         5: return 747; 6: return 559; default: return 1122;
      endcase
   endfunction
   function automatic int hi_of(input int c);
      case (c)
         1: return 260; 2: return 310; 6: return 560; default: return lo_of(c);
      endcase
   endfunction

   // R5 R6 R7 R8 model update for one received word
   function automatic void model_word(input int w);
      int code = 0;
      int odd  = 1;
      for (int c = 1; c <= 7; c++)
         if (w >= lo_of(c) - 1 && w <= hi_of(c) + 1) begin
            code = c;
            odd  = (lo_of(c) == hi_of(c)) ? 1 : int'(w >= hi_of(c));
         end
      if (code == 0) begin
         m_unk  = 1;
         m_prev = 0;
      end else begin
         m_unk = 0;
         if (code == m_prev) begin
            m_fmt  = code;
            m_odd  = odd;
            m_comp = (w >> 8) & 1;
         end
         m_prev = code;
      end
   endfunction

   // one line of 40 clocks; first cycles carry noise (R3)
   task automatic do_line(input logic b, input bit vs_fall, input bit vs_rise);
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         hs_n    = (c < 4) ? 1'b0 : 1'b1;
         fmt_bit = (c < 3) ? 1'($urandom % 2) : b;
         if (c == 25 && vs_fall) vs_n = 1'b0;
         if (c == 25 && vs_rise) vs_n = 1'b1;
      end
   endtask

   task automatic send_field(input int w, input string tag);
      do_line(1'($urandom % 2), 1'b1, 1'b0);            // line with VS leading edge
      do_line(1'($urandom % 2), 1'b0, 1'b0);            // R9 outside window
      do_line(1'($urandom % 2), 1'b0, 1'b0);
      for (int k = 10; k >= 0; k--)                     // R2 MSB first from 3rd edge
         do_line(1'((w >> k) & 1), 1'b0, k == 10);
      for (int k = 0; k < 3; k++)
         do_line(1'($urandom % 2), 1'b0, 1'b0);         // R9 outside window
      model_word(w);
      @(negedge clk);
      check({tag, " R4 R6 fmt_code"}, int'(fmt_code), m_fmt);
      check({tag, " R8 field_odd"},   int'(field_odd), m_odd);
      check({tag, " R7 composite"},   int'(composite), m_comp);
      check({tag, " R5 unknown"},     int'(unknown), m_unk);
   endtask

   initial begin
      #1_500_000ns;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int dummy;
      dummy = int'($urandom(32'd1981));
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 fmt_code", int'(fmt_code), 0);
      check("R1 field_odd", int'(field_odd), 1);
      check("R1 composite", int'(composite), 0);
      check("R1 unknown", int'(unknown), 0);
      rst_n = 1'b1;
      repeat (3) do_line(1'b0, 1'b0, 1'b0);

      send_field(260, "525i first");             // R6 not yet confirmed
      send_field(259, "525i second");            // R4 code 1, R8 even, R7 composite
      send_field(260, "525i odd");
      send_field(523, "525p upper edge");        // R5 tolerance
      send_field(521, "525p lower edge");
      send_field(524, "out of band");            // R5 unknown, hold
      send_field(622, "625p after unknown");     // R6 run broken
      send_field(622, "625p confirmed");
      send_field(311, "625i upper");
      send_field(308, "625i lower even");
      send_field(1122, "1080p a");
      send_field(1121, "1080p b");
      send_field(560, "1080i odd");
      send_field(559, "1080i even");
      send_field(747, "720p a");
      send_field(748, "720p b");
      send_field(257, "below 525i band");        // R5
      send_field(0, "zero word");

      for (int i = 0; i < 40; i++) begin
         int c = 1 + int'($urandom % 7);
         int w;
         case ($urandom % 4)
            0: w = int'($urandom % 2048);
            1: w = lo_of(c) - 1;
            2: w = hi_of(c) + 1;
            default: w = ($urandom % 2) ? lo_of(c) : hi_of(c);
         endcase
         send_field(w, "random");
         if ($urandom % 3 != 0) send_field(w, "random repeat");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule